// File: doc/BRIEF.md
# Continuous Read Address Sequencer

This block produces the page index and byte offset that a serial flash array needs during a continuous read. The command decoder hands it the three address bytes that follow the opcode, most significant byte first, one byte per strobe. When the third byte arrives, the block splits the assembled value into a page index and a byte offset. The split depends on the page-size select: 512-byte binary pages or 528-byte pages. From that point on, each byte-advance strobe moves the read pointer forward by one byte. At the end of a page the pointer continues at byte 0 of the following page with no added cycle. After the highest page it returns to page 0.

The page-size select is captured only when the address is loaded. The read ends when chip select returns high. The pointer then holds its last value and the block waits for a new address. In 528-byte mode a loaded offset beyond the page is clamped to the last byte of the page, and an error flag is raised for the rest of that read.

Top module: `crd_addresser`

## Requirements
- R1: After reset, pageIdx and byteOff are 0, and addrReady and offErr are low.
- R2: While chip select is low, address bytes are taken most significant first, one per cycle in which addrByteValid is high. addrReady stays low until the third byte and rises on the clock edge that takes the third byte.
- R3: With mode528 low at load, the 24 address bits are treated as a flat value. Bits 21..9 become pageIdx, bits 8..0 become byteOff (zero-extended), and bits 23..22 are ignored.
- R4: With mode528 high at load, bits 22..10 of the 24 address bits become pageIdx, bits 9..0 become byteOff, and bit 23 is ignored.
- R5: While addrReady is high and chip select is low, each cycle with advance high raises byteOff by one and leaves pageIdx unchanged, provided byteOff is below the last byte of the page. The new values appear at the next clock edge.
- R6: In 512-byte mode, an advance at byteOff 511 gives byteOff 0 and pageIdx plus one, in a single cycle.
- R7: In 528-byte mode, an advance at byteOff 527 gives byteOff 0 and pageIdx plus one, in a single cycle. Offsets 511 to 512 step normally in this mode.
- R8: An advance past the last byte of page 8191 gives page 0, byte 0.
- R9: In 528-byte mode, a loaded offset of 528 or more is replaced by 527 and offErr rises. offErr stays high until chip select rises.
- R10: A change on mode528 after the load has no effect on stepping until the next load.
- R11: When chip select is high, addrReady and offErr go low at the next edge, pageIdx and byteOff hold, advance is ignored, and the byte count restarts. Advance is also ignored before an address has been loaded.
- R12: Address bytes strobed after the third byte of a read are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low; high ends the read |
| addrByte | input | 8 | Address byte from the command decoder |
| addrByteValid | input | 1 | Load strobe for addrByte |
| advance | input | 1 | One data byte has been clocked out |
| mode528 | input | 1 | Page-size select: 1 = 528-byte pages, 0 = 512-byte binary pages |
| pageIdx | output | 13 | Current page index |
| byteOff | output | 10 | Current byte offset within the page |
| addrReady | output | 1 | Address loaded; pointer is live |
| offErr | output | 1 | A loaded 528-mode offset was out of range and was clamped |

## Verification
Every cycle, the assertions check the single-step increment, both page-end wraps (including the roll from page 8191 to 0), that the offset never leaves the 528-byte window, that the pointer holds when no step is taken, and that a high chip select clears the ready and error flags. The field split of the three loaded bytes in each mode, the capture of the page-size select only at load, the rejection of a fourth byte, and the exact cycle in which addrReady rises can only be shown by the bench's scenarios. These depend on byte values and on the sequence of strobes across several cycles.

// File: rtl/crd_pkg.sv
package crd_pkg;
  // strobes issued by the control FSM to the address datapath
  typedef struct packed {
    logic shiftIn;   // take addrByte into the assembly register
    logic loadAddr;  // final address byte: split and load the pointer
    logic stepByte;  // move the pointer forward by one byte
    logic clear;     // end of read: drop the error flag
    logic ext;       // page size in force (1 = 528 bytes)
  } crdStrobes_t;
endpackage

// File: rtl/crd_ctrl.sv
module crd_ctrl
  import crd_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        addrByteValid,
  input  logic        advance,
  input  logic        mode528,
  output crdStrobes_t strobes,
  output logic        addrReady
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic             readyQ;
  logic             modeQ;

  always_comb begin
    strobes          = '0;
    strobes.clear    = csN;
    strobes.shiftIn  = !csN && addrByteValid && (byteCnt < CNT_FULL);
    strobes.loadAddr = strobes.shiftIn && (byteCnt == CNT_LAST);
    strobes.stepByte = !csN && readyQ && advance;
    strobes.ext      = strobes.loadAddr ? mode528 : modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      readyQ  <= 1'b0;
      modeQ   <= 1'b0;
    end else if (csN) begin
      byteCnt <= '0;
      readyQ  <= 1'b0;
    end else begin
      if (strobes.shiftIn) byteCnt <= byteCnt + CNT_W'(1);
      if (strobes.loadAddr) begin
        readyQ <= 1'b1;
        modeQ  <= mode528;
      end
    end
  end

  assign addrReady = readyQ;
endmodule

// File: rtl/crd_datapath.sv
module crd_datapath
  import crd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PAGE_BITS  = 13,
  parameter int OFF_BITS   = 10,
  parameter int BIN_PAGE   = 512,
  parameter int EXT_PAGE   = 528
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  crdStrobes_t          strobes,
  input  logic [7:0]           addrByte,
  output logic [PAGE_BITS-1:0] pageIdx,
  output logic [OFF_BITS-1:0]  byteOff,
  output logic                 offErr
);
  localparam int ASM_W        = ADDR_BYTES * 8;
  localparam int BIN_OFF_BITS = $clog2(BIN_PAGE);
  localparam logic [OFF_BITS-1:0] LAST_BIN = OFF_BITS'(BIN_PAGE - 1);
  localparam logic [OFF_BITS-1:0] LAST_EXT = OFF_BITS'(EXT_PAGE - 1);

  logic [ASM_W-1:0]     asmQ;
  logic [ASM_W-1:0]     asmNext;
  logic [PAGE_BITS-1:0] loadPage;
  logic [OFF_BITS-1:0]  loadOff;
  logic                 loadBad;
  logic [OFF_BITS-1:0]  lastOff;
  logic                 atEnd;

  assign asmNext = {asmQ[ASM_W-9:0], addrByte};

  // field split at load time, chosen by the page size captured with the last byte
  always_comb begin
    loadBad = 1'b0;
    if (strobes.ext) begin
      loadPage = asmNext[OFF_BITS+PAGE_BITS-1:OFF_BITS];
      loadOff  = asmNext[OFF_BITS-1:0];
      if (loadOff > LAST_EXT) begin
        loadOff = LAST_EXT;
        loadBad = 1'b1;
      end
    end else begin
      loadPage = asmNext[BIN_OFF_BITS+PAGE_BITS-1:BIN_OFF_BITS];
      loadOff  = OFF_BITS'(asmNext[BIN_OFF_BITS-1:0]);
    end
  end

  assign lastOff = strobes.ext ? LAST_EXT : LAST_BIN;
  assign atEnd   = (byteOff >= lastOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmQ    <= '0;
      pageIdx <= '0;
      byteOff <= '0;
      offErr  <= 1'b0;
    end else begin
      if (strobes.shiftIn) asmQ <= asmNext;
      if (strobes.clear) begin
        offErr <= 1'b0;
      end else if (strobes.loadAddr) begin
        pageIdx <= loadPage;
        byteOff <= loadOff;
        offErr  <= loadBad;
      end else if (strobes.stepByte) begin
        if (atEnd) begin
          byteOff <= '0;
          pageIdx <= pageIdx + PAGE_BITS'(1);
        end else begin
          byteOff <= byteOff + OFF_BITS'(1);
        end
      end
    end
  end
endmodule

// File: rtl/crd_addresser.sv
module crd_addresser
  import crd_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int PAGE_BITS  = 13,
  parameter int OFF_BITS   = 10,
  parameter int BIN_PAGE   = 512,
  parameter int EXT_PAGE   = 528
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic [7:0]           addrByte,
  input  logic                 addrByteValid,
  input  logic                 advance,
  input  logic                 mode528,
  output logic [PAGE_BITS-1:0] pageIdx,
  output logic [OFF_BITS-1:0]  byteOff,
  output logic                 addrReady,
  output logic                 offErr
);
  crdStrobes_t strobes;

  crd_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .addrByteValid(addrByteValid),
    .advance(advance), .mode528(mode528), .strobes(strobes), .addrReady(addrReady)
  );

  crd_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS),
    .BIN_PAGE(BIN_PAGE), .EXT_PAGE(EXT_PAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrByte(addrByte),
    .pageIdx(pageIdx), .byteOff(byteOff), .offErr(offErr)
  );
endmodule

// File: rtl/crd_addresser_chk.sv
module crd_addresser_chk #(
  parameter int PAGE_BITS = 13,
  parameter int OFF_BITS  = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 addrByteValid,
  input logic                 advance,
  input logic [PAGE_BITS-1:0] pageIdx,
  input logic [OFF_BITS-1:0]  byteOff,
  input logic                 addrReady,
  input logic                 offErr
);
  p_ready_on_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrReady) |-> ($past(addrByteValid) && !$past(csN)));

  p_step_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && addrReady && advance && byteOff < OFF_BITS'(511)) |=>
      (byteOff == OFF_BITS'($past(byteOff) + 1'b1)) && $stable(pageIdx));

  p_wrap_bin_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && addrReady && advance && byteOff == OFF_BITS'(511)) |=>
      ((byteOff == '0 && pageIdx == PAGE_BITS'($past(pageIdx) + 1'b1)) ||
       (byteOff == OFF_BITS'(512) && $stable(pageIdx))));

  // covers R8 as well: the page sum wraps at the field width
  p_wrap_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && addrReady && advance && byteOff == OFF_BITS'(527)) |=>
      (byteOff == '0 && pageIdx == PAGE_BITS'($past(pageIdx) + 1'b1)));

  p_off_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteOff <= OFF_BITS'(527));

  p_clamp_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offErr) |-> (byteOff == OFF_BITS'(527)));

  p_cs_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!addrReady && !offErr));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addrReady && (!advance || csN)) |=> ($stable(pageIdx) && $stable(byteOff)));
endmodule

bind crd_addresser crd_addresser_chk #(.PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .addrByteValid(addrByteValid), .advance(advance),
  .pageIdx(pageIdx), .byteOff(byteOff), .addrReady(addrReady), .offErr(offErr)
);

// File: tb/crd_addresser_bench.sv
`timescale 1ns/1ps
module crd_addresser_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic [7:0]  addrByte = '0;
  logic        addrByteValid = 1'b0;
  logic        advance = 1'b0;
  logic        mode528 = 1'b0;
  logic [12:0] pageIdx;
  logic [9:0]  byteOff;
  logic        addrReady;
  logic        offErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  crd_addresser u_crd_addresser (
    .clk(clk), .rstN(rstN), .csN(csN), .addrByte(addrByte),
    .addrByteValid(addrByteValid), .advance(advance), .mode528(mode528),
    .pageIdx(pageIdx), .byteOff(byteOff), .addrReady(addrReady), .offErr(offErr)
  );

  // expected item: {ready, err, page[12:0], off[9:0]}
  logic [24:0] expQ[$];
  string       reqQ[$];

  // reference state built from the requirements
  logic [23:0] mAsm = '0;
  logic [12:0] mPage = '0;
  logic [9:0]  mOff = '0;
  logic        mReady = 1'b0;
  logic        mErr = 1'b0;
  logic        mMode = 1'b0;
  int          mCnt = 0;

  task automatic cyc(input logic cs, input logic v, input logic [7:0] b,
                     input logic adv, input logic m, input string req);
    @(negedge clk);
    csN = cs; addrByteValid = v; addrByte = b; advance = adv; mode528 = m;
    if (cs) begin
      mReady = 1'b0; mErr = 1'b0; mCnt = 0;
    end else if (v && mCnt < 3) begin
      mAsm = {mAsm[15:0], b};
      mCnt++;
      if (mCnt == 3) begin
        mReady = 1'b1;
        mMode  = m;
        if (m) begin
          mPage = mAsm[22:10];
          mOff  = mAsm[9:0];
          if (mOff > 10'd527) begin mOff = 10'd527; mErr = 1'b1; end
        end else begin
          mPage = mAsm[21:9];
          mOff  = {1'b0, mAsm[8:0]};
        end
      end
    end else if (adv && mReady) begin
      if (mOff == (mMode ? 10'd527 : 10'd511)) begin
        mOff = '0; mPage = mPage + 13'd1;
      end else begin
        mOff = mOff + 10'd1;
      end
    end
    expQ.push_back({mReady, mErr, mPage, mOff});
    reqQ.push_back(req);
  endtask

  task automatic loadAddr(input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input logic m, input string req);
    cyc(1'b0, 1'b1, b0, 1'b0, m, "R2");
    cyc(1'b0, 1'b1, b1, 1'b0, m, "R2");
    cyc(1'b0, 1'b1, b2, 1'b0, m, req);
  endtask

  task automatic stepN(input int n, input logic m, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, m, req);
  endtask

  task automatic endRead();
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R11");
  endtask

  // monitor: compares one expected item per cycle after the edge it belongs to
  initial begin
    logic [24:0] e;
    logic [24:0] act;
    string r;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        r = reqQ.pop_front();
        act = {addrReady, offErr, pageIdx, byteOff};
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s: ready=%0b err=%0b page=%0d off=%0d, expected ready=%0b err=%0b page=%0d off=%0d",
                   r, act[24], act[23], act[22:10], act[9:0], e[24], e[23], e[22:10], e[9:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
    // advance before any address: ignored (R11)
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R11");
    // binary mode, top bits ignored: page 0x91, offset 0x145 (R3)
    loadAddr(8'hC1, 8'h23, 8'h45, 1'b0, "R3");
    stepN(2, 1'b0, "R5");
    cyc(1'b0, 1'b1, 8'h99, 1'b0, 1'b0, "R12");
    cyc(1'b0, 1'b1, 8'h77, 1'b1, 1'b0, "R12");
    endRead();
    // binary page end: page 5 offset 510 (R6)
    loadAddr(8'h00, 8'h0B, 8'hFE, 1'b0, "R3");
    stepN(3, 1'b0, "R6");
    endRead();
    // 528 mode, page 8191 offset 526: page end and array end (R4, R7, R8)
    loadAddr(8'h7F, 8'hFE, 8'h0E, 1'b1, "R4");
    stepN(3, 1'b1, "R7");
    endRead();
    // 528 mode, page 1 offset 510, select flips to binary mid-read (R10)
    loadAddr(8'h00, 8'h05, 8'hFE, 1'b1, "R4");
    stepN(3, 1'b0, "R10");
    endRead();
    // 528 mode, page 3 offset 700: clamp and flag (R9)
    loadAddr(8'h00, 8'h0E, 8'hBC, 1'b1, "R9");
    stepN(2, 1'b1, "R9");
    // chip select high: flags drop, pointer holds, advance ignored (R11)
    cyc(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R11");
    cyc(1'b1, 1'b1, 8'h12, 1'b1, 1'b0, "R11");
    // binary mode, all ones: page 8191 offset 511 then wrap to page 0 (R8)
    loadAddr(8'hFF, 8'hFF, 8'hFF, 1'b0, "R3");
    stepN(2, 1'b0, "R8");
    endRead();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule